// File: doc/BRIEF.md
# Dual Sound Chip Stereo Controller

This block sits between a host bus and two sound generator cores. It decodes each bus write so that exactly one generator sees it. It also watches writes aimed at the second generator to decide whether the audio pair should run as stereo or as mono. At reset the block is in mono, and the first generator's sample feeds both output channels. A write to the second generator with meaningful data turns stereo on. In stereo, the left channel carries the first generator and the right channel carries the second.

Stereo turns off again after a configurable idle time with no meaningful writes to the second generator (30 seconds by default). An external level input can hold the output in mono whatever activity is seen. Writes whose data is all zeros or all ones are treated as start-up filler: they reach the second generator but do not count as activity. The second generator's interrupt line reaches the host only when a configuration bit enables it.

Top module: `stc_stereo_ctrl`

## Requirements
- R1: A write (`bus_wr` high) with address bit 4 low asserts `chip_a_wr` in the same cycle. With bit 4 high it asserts `chip_b_wr` instead. The two are never high together, and neither is high without `bus_wr`. If bit 4 is tied low, every write goes to the first generator.
- R2: While `rst` is high, and right after it, `stereo_active`, `left_out`, `right_out` and `host_irq2` are all 0. Reset also clears the idle timer, the detected activity and the interrupt enable.
- R3: While `stereo_active` is 0, `left_out` and `right_out` both equal `chip_a_audio` as sampled at the previous clock edge. `chip_b_audio` is discarded.
- R4: Take a qualifying write to the second generator, sampled at edge k, with `stereo_allow` held high. From edge k+1, `stereo_active` is 1, `left_out` follows `chip_a_audio` and `right_out` follows `chip_b_audio`, each one cycle late.
- R5: A write to the second generator whose data is 0x00 or 0xFF is not qualifying. It leaves the mode and the idle timer unchanged.
- R6: Writes to the first generator never turn stereo on and never reload the idle timer.
- R7: `stereo_allow` passes through a two-flop synchroniser. A low level sampled at edge e gives mono outputs from edge e+2 onward, while detection keeps running. When the input returns high, stereo resumes if activity is still current.
- R8: With `LIMIT = CLK_HZ * IDLE_SECONDS`, a last qualifying write sampled at edge k keeps stereo through edge k+LIMIT. The outputs are mono from edge k+LIMIT+1. Any qualifying write restarts this window.
- R9: `host_irq2` equals `chip_b_irq` AND the interrupt enable bit. That bit is written through `cfg_wr` / `cfg_irq_en`, takes effect after the clock edge, and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Host register address; bit CHIP_SEL_BIT selects the second generator |
| bus_wdata | input | DATA_W | Host write data |
| chip_a_wr | output | 1 | Write strobe for the first generator |
| chip_b_wr | output | 1 | Write strobe for the second generator |
| stereo_allow | input | 1 | Asynchronous level: high permits stereo, low forces mono |
| cfg_wr | input | 1 | Load strobe for the interrupt enable bit |
| cfg_irq_en | input | 1 | New value of the interrupt enable bit |
| chip_a_audio | input | SAMPLE_W | Unsigned sample from the first generator |
| chip_b_audio | input | SAMPLE_W | Unsigned sample from the second generator |
| chip_b_irq | input | 1 | Interrupt request from the second generator |
| host_irq2 | output | 1 | Gated interrupt request to the host |
| left_out | output | SAMPLE_W | Registered left channel sample |
| right_out | output | SAMPLE_W | Registered right channel sample |
| stereo_active | output | 1 | 1 while the outputs are routed as stereo |

## Verification
Suppose the activity state or the idle counter goes wrong. `stereo_active` and `right_out` then disagree with the write history one cycle after the faulty edge. This shows up as a premature return to mono or as a window that never closes. The bench checks the exact boundary cycle of the idle window, so an off-by-one in the counter is caught.

A broken filler filter or a broken address decode turns stereo on two edges after a write that should be ignored. A wrong synchroniser depth moves the forced-mono edge by a cycle, and the bench samples on both sides of that edge.

// File: rtl/stc_pkg.sv
package stc_pkg;

    typedef enum logic {
        DET_IDLE   = 1'b0,
        DET_ACTIVE = 1'b1
    } det_state_e;

    typedef enum logic {
        ROUTE_MONO   = 1'b0,
        ROUTE_STEREO = 1'b1
    } route_mode_e;

    typedef struct packed {
        logic wr_a;
        logic wr_b;
        logic qualify;
    } snoop_t;

    function automatic int unsigned idle_limit(input int unsigned hz, input int unsigned secs);
        return hz * secs;
    endfunction

endpackage

// File: rtl/stc_write_snoop.sv
module stc_write_snoop
    import stc_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 8,
    parameter int SEL_BIT  = 4
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output snoop_t            snoop
);
    localparam logic [DATA_W-1:0] FILL_LO = '0;
    localparam logic [DATA_W-1:0] FILL_HI = '1;

    logic to_b;
    logic filler;

    always_comb begin
        to_b          = addr[SEL_BIT];
        filler        = (wdata == FILL_LO) || (wdata == FILL_HI);
        snoop.wr_a    = wr && !to_b;
        snoop.wr_b    = wr && to_b;
        snoop.qualify = wr && to_b && !filler;
    end
endmodule

// File: rtl/stc_activity.sv
module stc_activity
    import stc_pkg::*;
#(
    parameter int unsigned LIMIT = 1500000000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       qualify,
    output det_state_e state
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= DET_IDLE;
            remain <= '0;
        end else if (qualify) begin
            state  <= DET_ACTIVE;
            remain <= RELOAD;
        end else if (state == DET_ACTIVE) begin
            if (remain == '0) begin
                state <= DET_IDLE;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end
endmodule

// File: rtl/stc_sync.sv
module stc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/stc_router.sv
module stc_router
    import stc_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  det_state_e          det,
    input  logic                allow,
    input  logic [SAMPLE_W-1:0] src_a,
    input  logic [SAMPLE_W-1:0] src_b,
    output logic [SAMPLE_W-1:0] left_q,
    output logic [SAMPLE_W-1:0] right_q,
    output route_mode_e         mode
);
    route_mode_e next_mode;

    always_comb begin
        next_mode = (det == DET_ACTIVE && allow) ? ROUTE_STEREO : ROUTE_MONO;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q  <= '0;
            right_q <= '0;
            mode    <= ROUTE_MONO;
        end else begin
            mode    <= next_mode;
            left_q  <= src_a;
            right_q <= (next_mode == ROUTE_STEREO) ? src_b : src_a;
        end
    end
endmodule

// File: rtl/stc_stereo_ctrl.sv
module stc_stereo_ctrl
    import stc_pkg::*;
#(
    parameter int SAMPLE_W     = 12,
    parameter int ADDR_W       = 5,
    parameter int DATA_W       = 8,
    parameter int CHIP_SEL_BIT = 4,
    parameter int CLK_HZ       = 50000000,
    parameter int IDLE_SECONDS = 30,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic                chip_a_wr,
    output logic                chip_b_wr,
    input  logic                stereo_allow,
    input  logic                cfg_wr,
    input  logic                cfg_irq_en,
    input  logic [SAMPLE_W-1:0] chip_a_audio,
    input  logic [SAMPLE_W-1:0] chip_b_audio,
    input  logic                chip_b_irq,
    output logic                host_irq2,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                stereo_active
);
    localparam int unsigned IDLE_LIMIT = idle_limit(CLK_HZ, IDLE_SECONDS);

    snoop_t      snoop;
    det_state_e  det;
    logic        allow_s;
    route_mode_e mode;
    logic        irq_en_q;

    stc_write_snoop #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SEL_BIT(CHIP_SEL_BIT)
    ) u_snoop (
        .wr   (bus_wr),
        .addr (bus_addr),
        .wdata(bus_wdata),
        .snoop(snoop)
    );

    stc_activity #(
        .LIMIT(IDLE_LIMIT)
    ) u_act (
        .clk    (clk),
        .rst    (rst),
        .qualify(snoop.qualify),
        .state  (det)
    );

    stc_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (stereo_allow),
        .q  (allow_s)
    );

    stc_router #(
        .SAMPLE_W(SAMPLE_W)
    ) u_route (
        .clk    (clk),
        .rst    (rst),
        .det    (det),
        .allow  (allow_s),
        .src_a  (chip_a_audio),
        .src_b  (chip_b_audio),
        .left_q (left_out),
        .right_q(right_out),
        .mode   (mode)
    );

    always_ff @(posedge clk) begin
        if (rst)         irq_en_q <= 1'b0;
        else if (cfg_wr) irq_en_q <= cfg_irq_en;
    end

    assign chip_a_wr     = snoop.wr_a;
    assign chip_b_wr     = snoop.wr_b;
    assign host_irq2     = chip_b_irq && irq_en_q;
    assign stereo_active = (mode == ROUTE_STEREO);
endmodule

// File: rtl/stc_stereo_ctrl_chk.sv
module stc_stereo_ctrl_chk #(
    parameter int SAMPLE_W     = 12,
    parameter int ADDR_W       = 5,
    parameter int DATA_W       = 8,
    parameter int CHIP_SEL_BIT = 4,
    parameter int CLK_HZ       = 50000000,
    parameter int IDLE_SECONDS = 30
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic                chip_a_wr,
    input logic                chip_b_wr,
    input logic                stereo_allow,
    input logic                cfg_wr,
    input logic                cfg_irq_en,
    input logic [SAMPLE_W-1:0] chip_a_audio,
    input logic [SAMPLE_W-1:0] chip_b_audio,
    input logic                chip_b_irq,
    input logic                host_irq2,
    input logic [SAMPLE_W-1:0] left_out,
    input logic [SAMPLE_W-1:0] right_out,
    input logic                stereo_active
);
    localparam logic [31:0] LIM = 32'(CLK_HZ) * 32'(IDLE_SECONDS);

    logic        port_qual;
    logic [31:0] since_q;

    assign port_qual = bus_wr && bus_addr[CHIP_SEL_BIT]
                       && (bus_wdata != '0) && (bus_wdata != '1);

    always_ff @(posedge clk) begin
        if (rst)              since_q <= LIM + 32'd1;
        else if (port_qual)   since_q <= '0;
        else if (since_q <= LIM) since_q <= since_q + 32'd1;
    end

    p_decode_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({chip_a_wr, chip_b_wr}) && ((chip_a_wr || chip_b_wr) == bus_wr));

    p_mono_follow_r3: assert property (@(posedge clk) disable iff (rst)
        (!stereo_active && !$past(rst)) |->
            (left_out == $past(chip_a_audio) && right_out == $past(chip_a_audio)));

    p_stereo_split_r4: assert property (@(posedge clk) disable iff (rst)
        stereo_active |->
            (left_out == $past(chip_a_audio) && right_out == $past(chip_b_audio)));

    p_force_mono_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(stereo_allow, 3) |-> !stereo_active);

    // also covers R5 and R6: filler and first-generator writes never restart the window
    p_idle_limit_r8: assert property (@(posedge clk) disable iff (rst)
        stereo_active |-> (since_q <= LIM));

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
        host_irq2 |-> chip_b_irq);

    p_irq_off_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_wr) && !$past(cfg_irq_en)) |-> !host_irq2);
endmodule

bind stc_stereo_ctrl stc_stereo_ctrl_chk #(
    .SAMPLE_W    (SAMPLE_W),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .CHIP_SEL_BIT(CHIP_SEL_BIT),
    .CLK_HZ      (CLK_HZ),
    .IDLE_SECONDS(IDLE_SECONDS)
) u_chk (.*);

// File: tb/tb_stc_stereo_ctrl.sv
module tb_stc_stereo_ctrl;
    localparam int SW    = 12;
    localparam int HZ    = 8;
    localparam int SECS  = 5;
    localparam int LIMIT = HZ * SECS;
    localparam logic [SW-1:0] AUD_A = 12'h3C1;
    localparam logic [SW-1:0] AUD_B = 12'hA52;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_wr;
    logic [4:0]    bus_addr;
    logic [7:0]    bus_wdata;
    logic          chip_a_wr, chip_b_wr;
    logic          stereo_allow;
    logic          cfg_wr, cfg_irq_en;
    logic [SW-1:0] chip_a_audio, chip_b_audio;
    logic          chip_b_irq;
    logic          host_irq2;
    logic [SW-1:0] left_out, right_out;
    logic          stereo_active;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    stc_stereo_ctrl #(
        .SAMPLE_W    (SW),
        .CLK_HZ      (HZ),
        .IDLE_SECONDS(SECS)
    ) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .chip_a_wr(chip_a_wr), .chip_b_wr(chip_b_wr),
        .stereo_allow(stereo_allow), .cfg_wr(cfg_wr), .cfg_irq_en(cfg_irq_en),
        .chip_a_audio(chip_a_audio), .chip_b_audio(chip_b_audio),
        .chip_b_irq(chip_b_irq), .host_irq2(host_irq2),
        .left_out(left_out), .right_out(right_out), .stereo_active(stereo_active)
    );

    // {addr[4:0], data[7:0], expect chip_b_wr, expect stereo two edges later}
    localparam logic [14:0] VEC [0:6] = '{
        {5'h00, 8'h55, 1'b0, 1'b0},   // R6: first generator
        {5'h10, 8'h00, 1'b1, 1'b0},   // R5: filler zero
        {5'h1F, 8'hFF, 1'b1, 1'b0},   // R5: filler ones
        {5'h0F, 8'h12, 1'b0, 1'b0},   // R6/R1: bit 4 low
        {5'h10, 8'h01, 1'b1, 1'b1},   // R4: qualifying
        {5'h12, 8'hFF, 1'b1, 1'b1},   // R5: filler keeps stereo
        {5'h05, 8'h80, 1'b0, 1'b1}    // R6: first generator keeps stereo
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d,
                             input logic exp_b, input string req);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        #1;
        check(req, {30'd0, chip_a_wr, chip_b_wr}, {30'd0, !exp_b, exp_b});
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic expect_route(input logic st, input string req);
        check({req, " mode"},  32'(stereo_active), 32'(st));
        check({req, " left"},  32'(left_out),  32'(AUD_A));
        check({req, " right"}, 32'(right_out), st ? 32'(AUD_B) : 32'(AUD_A));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        stereo_allow = 1'b1; cfg_wr = 1'b0; cfg_irq_en = 1'b0;
        chip_a_audio = AUD_A; chip_b_audio = AUD_B; chip_b_irq = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2 reset mode", 32'(stereo_active), 0);
        check("R2 reset left", 32'(left_out), 0);
        check("R2 reset right", 32'(right_out), 0);
        check("R2 reset irq", 32'(host_irq2), 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        expect_route(1'b0, "R3 mono after reset");

        for (int i = 0; i < 7; i++) begin
            bus_write(VEC[i][14:10], VEC[i][9:2], VEC[i][1], "R1 decode");
            @(posedge clk);
            @(negedge clk);
            expect_route(VEC[i][0], $sformatf("R4/R5/R6 vector %0d", i));
        end

        // R8: exact idle boundary
        bus_write(5'h10, 8'h42, 1'b1, "R1 decode");
        repeat (LIMIT) @(posedge clk);
        @(negedge clk);
        expect_route(1'b1, "R8 last stereo edge");
        @(posedge clk);
        @(negedge clk);
        expect_route(1'b0, "R8 timeout to mono");

        // R8: reload extends window
        bus_write(5'h11, 8'h07, 1'b1, "R1 decode");
        repeat (30) @(posedge clk);
        @(negedge clk);
        bus_write(5'h13, 8'h08, 1'b1, "R1 decode");
        repeat (20) @(posedge clk);
        @(negedge clk);
        expect_route(1'b1, "R8 reload keeps stereo");

        // R7: force pin latency and override
        stereo_allow = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R7 sync latency", 32'(stereo_active), 1);
        @(posedge clk);
        @(negedge clk);
        expect_route(1'b0, "R7 forced mono");
        bus_write(5'h14, 8'h33, 1'b1, "R1 decode");
        @(posedge clk);
        @(negedge clk);
        expect_route(1'b0, "R7 forced despite write");
        stereo_allow = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        expect_route(1'b1, "R7 released back to stereo");

        // R9: interrupt gating
        check("R9 irq disabled", 32'(host_irq2), 0);
        cfg_wr = 1'b1; cfg_irq_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
        check("R9 irq enabled", 32'(host_irq2), 1);
        chip_b_irq = 1'b0;
        #1;
        check("R9 irq follows source", 32'(host_irq2), 0);
        chip_b_irq = 1'b1;

        // R2: reset from stereo with irq enabled
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R2 reset clears mode", 32'(stereo_active), 0);
        check("R2 reset clears irq enable", 32'(host_irq2), 0);
        rst = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        expect_route(1'b0, "R2 activity cleared");
        check("R2 irq stays off", 32'(host_irq2), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule